// File: doc/BRIEF.md
# Arithmetic and Mask Logic Unit with Flag Register

This unit combines a destination operand with a source operand. Its result path is combinational. It covers addition, subtraction with and without an incoming carry, compare, the four bitwise operations, and three mask operations: clear bits, set bits and test bits. A write-enable tells the surrounding datapath whether the result should be stored. Compare and bit-test set only the flags, so the enable stays low for them.

Four condition flags are kept in a register: carry, zero, negative and signed overflow. They are updated on every clock edge from the operation presented in that cycle. The carry input is supplied by the caller and is normally the registered carry fed back. Subtraction is performed as dest + NOT(src) + carry-in, so a cleared carry after a subtraction means a borrow occurred.

Each operation runs at either word width (parameter `W`, default 16) or byte width. In byte mode only the low eight bits take part, the flags come from bit 7, and the upper bits of the result are forced to zero.

Top module: `mask_alu`

## Requirements
- R1: Code 0 gives dest + src and code 1 gives dest + src + c_in. Both assert wr_en, and carry is the carry out of the most significant bit.
- R2: Code 2 gives dest + NOT(src) + 1 and code 3 gives dest + NOT(src) + c_in. Both assert wr_en, and carry is 1 when no borrow occurred and 0 on a borrow.
- R3: Code 4 (compare) sets the flags exactly as code 2 would, shows the difference on res, and holds wr_en low.
- R4: Codes 5, 6 and 7 give the bitwise AND, OR and XOR of dest with src. Code 8 gives NOT dest. All four assert wr_en.
- R5: Code 9 clears the dest bits where src has ones, code 10 sets them, and code 11 (bit-test) shows dest AND src with wr_en low.
- R6: When byte_mode is 1, only bits 7:0 take part, res bits W-1:8 are zero, carry comes out of bit 7, and the negative and overflow flags use bit 7.
- R7: At each clock edge flag_z takes the value (res == 0) and flag_n takes the top active bit of res for the operation just presented.
- R8: flag_v is signed overflow for codes 0 to 4 and is cleared by codes 5 to 11.
- R9: For codes 5 to 11, flag_c is the inverse of flag_z.
- R10: Codes 12 to 15 are reserved. They give res = 0 and wr_en = 0 and leave all four flags unchanged.
- R11: While rst_n is low, all four flags are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Active-low reset of the flags |
| op | input | 4 | Operation code |
| byte_mode | input | 1 | 1 selects byte width, 0 selects word width |
| dst | input | W | Destination operand |
| src | input | W | Source operand or mask |
| c_in | input | 1 | Carry input for codes 1 and 3 |
| res | output | W | Operation result |
| wr_en | output | 1 | Result should be written back |
| flag_c | output | 1 | Registered carry flag |
| flag_z | output | 1 | Registered zero flag |
| flag_n | output | 1 | Registered negative flag |
| flag_v | output | 1 | Registered overflow flag |

## Verification
The hardest cases depend on flag state that earlier operations left behind. To show that a logic operation clears overflow, the stimulus must first set overflow with a signed add. To show that reserved codes hold the flags, the register must first hold a non-trivial pattern. The vector table is therefore ordered so that an overflowing add is followed at once by an OR, and a compare with a borrow runs just before a reserved code. Byte-mode carries are driven with nonzero upper operand bits, so a carry taken from the wrong bit changes the result.

// File: rtl/mask_alu.sv
module mask_alu #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   op,
  input  logic         byte_mode,
  input  logic [W-1:0] dst,
  input  logic [W-1:0] src,
  input  logic         c_in,
  output logic [W-1:0] res,
  output logic         wr_en,
  output logic         flag_c,
  output logic         flag_z,
  output logic         flag_n,
  output logic         flag_v
);
  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_ADDC = 4'd1;
  localparam logic [3:0] OP_SUB  = 4'd2;
  localparam logic [3:0] OP_SUBC = 4'd3;
  localparam logic [3:0] OP_CMP  = 4'd4;
  localparam logic [3:0] OP_AND  = 4'd5;
  localparam logic [3:0] OP_OR   = 4'd6;
  localparam logic [3:0] OP_XOR  = 4'd7;
  localparam logic [3:0] OP_NOT  = 4'd8;
  localparam logic [3:0] OP_BIC  = 4'd9;
  localparam logic [3:0] OP_BIS  = 4'd10;
  localparam logic [3:0] OP_BIT  = 4'd11;
  localparam int HI = W - 1;

  logic         is_arith, is_logic, is_sub, cin;
  logic [W-1:0] bsel, raw;
  logic [W:0]   sum_w;
  logic [8:0]   sum_b;
  logic         msb, amsb, bmsb, carry, zero;
  logic [3:0]   flags_q, flags_d;

  assign is_arith = (op <= OP_CMP);
  assign is_logic = (op >= OP_AND) && (op <= OP_BIT);
  assign is_sub   = (op == OP_SUB) || (op == OP_SUBC) || (op == OP_CMP);
  assign bsel     = is_sub ? ~src : src;

  always_comb begin
    case (op)
      OP_ADDC, OP_SUBC: cin = c_in;
      OP_SUB, OP_CMP:   cin = 1'b1;
      default:          cin = 1'b0;
    endcase
  end

  assign sum_w = {1'b0, dst} + {1'b0, bsel} + {{W{1'b0}}, cin};
  assign sum_b = {1'b0, dst[7:0]} + {1'b0, bsel[7:0]} + {8'd0, cin};

  always_comb begin
    case (op)
      OP_AND, OP_BIT: raw = dst & src;
      OP_OR,  OP_BIS: raw = dst | src;
      OP_XOR:         raw = dst ^ src;
      OP_NOT:         raw = ~dst;
      OP_BIC:         raw = dst & ~src;
      default:        raw = is_arith ? sum_w[W-1:0] : '0;
    endcase
  end

  assign res   = byte_mode ? {{(W-8){1'b0}}, raw[7:0]} : raw;
  assign wr_en = (op <= OP_SUBC) || (is_logic && op != OP_BIT);

  assign msb   = byte_mode ? raw[7]  : raw[HI];
  assign amsb  = byte_mode ? dst[7]  : dst[HI];
  assign bmsb  = byte_mode ? bsel[7] : bsel[HI];
  assign carry = byte_mode ? sum_b[8] : sum_w[W];
  assign zero  = (res == '0);

  always_comb begin
    if (is_arith)      flags_d = {carry, zero, msb, (amsb == bmsb) && (msb != amsb)};
    else if (is_logic) flags_d = {~zero, zero, msb, 1'b0};
    else               flags_d = flags_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign {flag_c, flag_z, flag_n, flag_v} = flags_q;

  assert_byte_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_mode |-> (res[W-1:8] == '0));
  assert_cmp_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CMP) |-> !wr_en);
  assert_bit_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_BIT) |-> !wr_en);
  assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op <= OP_BIT) |=> (flag_z == ($past(res) == '0)));
  assert_logic_v_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    is_logic |=> !flag_v);
  assert_logic_c_R9: assert property (@(posedge clk) disable iff (!rst_n)
    is_logic |=> (flag_c != flag_z));
  assert_reserved_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op > OP_BIT) |-> (res == '0 && !wr_en));
  assert_reserved_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op > OP_BIT) |=> $stable({flag_c, flag_z, flag_n, flag_v}));
endmodule

// File: tb/test_mask_alu.sv
module test_mask_alu;
  localparam int W = 16;
  localparam int NV = 23;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] op = 4'd0;
  logic byte_mode = 1'b0;
  logic [W-1:0] dst = '0, src = '0;
  logic c_in = 1'b0;
  logic [W-1:0] res;
  logic wr_en, flag_c, flag_z, flag_n, flag_v;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mask_alu #(.W(W)) i_mask_alu (
    .clk(clk), .rst_n(rst_n), .op(op), .byte_mode(byte_mode),
    .dst(dst), .src(src), .c_in(c_in), .res(res), .wr_en(wr_en),
    .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v)
  );

  // op, byte, dst, src, cin, expected res, expected wr_en, expected CZNV
  localparam logic [58:0] VEC [NV] = '{
    {4'd0,  1'b0, 16'h1234, 16'h0001, 1'b0, 16'h1235, 1'b1, 4'b0000},
    {4'd0,  1'b0, 16'hFFFF, 16'h0001, 1'b0, 16'h0000, 1'b1, 4'b1100},
    {4'd0,  1'b0, 16'h7FFF, 16'h0001, 1'b0, 16'h8000, 1'b1, 4'b0011},
    {4'd6,  1'b0, 16'h8000, 16'h0001, 1'b0, 16'h8001, 1'b1, 4'b1010},
    {4'd1,  1'b0, 16'h0001, 16'h0001, 1'b1, 16'h0003, 1'b1, 4'b0000},
    {4'd0,  1'b1, 16'h12FF, 16'h3401, 1'b0, 16'h0000, 1'b1, 4'b1100},
    {4'd0,  1'b1, 16'h007F, 16'h0001, 1'b0, 16'h0080, 1'b1, 4'b0011},
    {4'd2,  1'b0, 16'h0005, 16'h0003, 1'b0, 16'h0002, 1'b1, 4'b1000},
    {4'd2,  1'b0, 16'h0003, 16'h0005, 1'b1, 16'hFFFE, 1'b1, 4'b0010},
    {4'd3,  1'b0, 16'h0005, 16'h0003, 1'b0, 16'h0001, 1'b1, 4'b1000},
    {4'd2,  1'b0, 16'h8000, 16'h0001, 1'b0, 16'h7FFF, 1'b1, 4'b1001},
    {4'd4,  1'b0, 16'h0007, 16'h0007, 1'b0, 16'h0000, 1'b0, 4'b1100},
    {4'd5,  1'b0, 16'hF0F0, 16'h0FF0, 1'b0, 16'h00F0, 1'b1, 4'b1000},
    {4'd5,  1'b0, 16'hF0F0, 16'h0F0F, 1'b0, 16'h0000, 1'b1, 4'b0100},
    {4'd7,  1'b0, 16'h00FF, 16'h0012, 1'b0, 16'h00ED, 1'b1, 4'b1000},
    {4'd8,  1'b0, 16'h00FF, 16'h0000, 1'b0, 16'hFF00, 1'b1, 4'b1010},
    {4'd8,  1'b1, 16'h12FF, 16'h0000, 1'b0, 16'h0000, 1'b1, 4'b0100},
    {4'd9,  1'b0, 16'h00FF, 16'h0012, 1'b0, 16'h00ED, 1'b1, 4'b1000},
    {4'd10, 1'b1, 16'hAB00, 16'h0080, 1'b0, 16'h0080, 1'b1, 4'b1010},
    {4'd11, 1'b0, 16'h0010, 16'h0012, 1'b0, 16'h0010, 1'b0, 4'b1000},
    {4'd11, 1'b0, 16'h0001, 16'h0012, 1'b0, 16'h0000, 1'b0, 4'b0100},
    {4'd3,  1'b1, 16'h0000, 16'h0000, 1'b0, 16'h00FF, 1'b1, 4'b0010},
    {4'd4,  1'b0, 16'h0003, 16'h0005, 1'b0, 16'hFFFE, 1'b0, 4'b0010}
  };
  localparam string TAG [NV] = '{
    "R1", "R1", "R8", "R8", "R1", "R6", "R6", "R2", "R2", "R2", "R8", "R3",
    "R4", "R9", "R4", "R4", "R6", "R5", "R5", "R5", "R5", "R6", "R3"
  };

  task automatic check(input string tag, input logic [W-1:0] er,
                       input logic ew, input logic [3:0] ef);
    checks++;
    if (res !== er || wr_en !== ew || {flag_c, flag_z, flag_n, flag_v} !== ef) begin
      errors++;
      $display("FAIL %s: res=%h we=%b CZNV=%b, expected res=%h we=%b CZNV=%b",
               tag, res, wr_en, {flag_c, flag_z, flag_n, flag_v}, er, ew, ef);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({flag_c, flag_z, flag_n, flag_v} !== 4'b0000) begin
      errors++;
      $display("FAIL R11: CZNV=%b expected 0000", {flag_c, flag_z, flag_n, flag_v});
    end
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      op = VEC[i][58:55]; byte_mode = VEC[i][54];
      dst = VEC[i][53:38]; src = VEC[i][37:22]; c_in = VEC[i][21];
      @(negedge clk);
      check(TAG[i], VEC[i][20:5], VEC[i][4], VEC[i][3:0]);
    end
    // R10: reserved codes leave the flags from the last compare (0010)
    op = 4'd13; byte_mode = 1'b0; dst = 16'hFFFF; src = 16'h0001; c_in = 1'b1;
    @(negedge clk);
    check("R10", 16'h0000, 1'b0, 4'b0010);
    op = 4'd15;
    @(negedge clk);
    check("R10", 16'h0000, 1'b0, 4'b0010);
    // R7: flags follow the add presented in the previous cycle
    op = 4'd0; dst = 16'h0000; src = 16'h0000; c_in = 1'b0;
    @(negedge clk);
    check("R7", 16'h0000, 1'b1, 4'b0100);
    // R11: reset in mid run clears flags
    op = 4'd0; dst = 16'hFFFF; src = 16'h0001;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R11", 16'h0000, 1'b1, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule